// File: doc/BRIEF.md
# Conflict-Triggered Instruction Cache

This block is a small two-way set-associative instruction store that sits beside a three-stage fetch/decode/execute pipeline whose single program-memory bus carries both instruction fetches and some data accesses. Most fetches never touch the cache: the instruction is read over the bus and passed straight through. The cache is consulted only in a cycle where the instruction in execute uses the program-memory bus for data while fetch also wants it. In that cycle the bus belongs to the data access. If the fetched address is held in the cache, the instruction is delivered from the cache at no cost. Otherwise the block raises a one-cycle stall, reads the instruction over the bus in the following cycle, and loads it into the cache.

The fetch stage runs two stages ahead of execute, so the address looked up in a conflict cycle is the fetch address of that cycle, which is two instructions past the one causing the conflict. The cache holds 32 instructions as 16 sets of 2 ways. The set is chosen by the low four address bits, and each set keeps a single least-recently-used pointer. A freeze input keeps the contents fixed: hits are still served, but misses load nothing. Hit, miss and eviction pulses let a bench count loads and evictions per loop pass, which exposes thrash patterns such as three addresses competing for one set.

Top module: `pm_conflict_icache`

## Requirements
- R1: When `fetch_req`=1 and `conflict`=0 outside a fill cycle, `pm_rd`=1, `pm_addr`=`fetch_addr`, `instr_out`=`pm_rdata`, `instr_valid`=1 and `stall`=0 in the same cycle, and the cache contents are not changed (a later conflict lookup of that address still misses).
- R2: When `fetch_req`=1, `conflict`=1 and the address is cached, `hit_evt`=1, `instr_out` holds the cached instruction with `instr_valid`=1 in the same cycle, `pm_rd`=0 and `stall`=0.
- R3: When `fetch_req`=1, `conflict`=1 and the address is not cached, `miss_evt`=1, `stall`=1, `instr_valid`=0 and `pm_rd`=0 in that cycle. In the next cycle (the fill cycle), whatever the inputs are, `pm_rd`=1, `pm_addr` is the missed address, and `instr_out`=`pm_rdata` with `instr_valid`=1.
- R4: The set is `fetch_addr[3:0]` and the tag is the remaining upper address bits. Addresses with equal low four bits compete for the same two ways, and addresses in different sets never displace each other.
- R5: A miss fills an empty way of its set before any valid way is replaced. `evict_evt` pulses with `miss_evt` only when both ways of the set are valid and freeze is off.
- R6: Each set keeps one least-recently-used pointer. A hit or a fill makes the other way the replacement candidate, and a miss on a full set replaces the least recently used address.
- R7: While `freeze`=1, hits are served, misses still stall and still deliver in the fill cycle, and neither the stored entries nor the LRU pointers change. The freeze value of the miss cycle decides whether the fill loads.
- R8: Reset and a `flush` pulse clear every valid bit and every LRU pointer, so that every later conflict lookup misses until the address is loaded again.
- R9: `hit_evt` and `miss_evt` are single-cycle pulses, at most one per cycle. Three addresses sharing one set, fetched under conflict in turn, produce three evictions on every loop pass once the cache is warm.
- R10: With `fetch_req`=0 outside a fill cycle, `instr_valid`, `pm_rd`, `stall`, `hit_evt` and `miss_evt` are all 0, even when `conflict`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries and clear LRU pointers |
| fetch_req | input | 1 | Fetch stage requests an instruction this cycle |
| fetch_addr | input | ADDR_W | Address of the requested instruction |
| conflict | input | 1 | Execute stage uses the program-memory bus for data this cycle |
| freeze | input | 1 | Block all cache loads and LRU updates |
| pm_rd | output | 1 | Instruction read on the program-memory bus |
| pm_addr | output | ADDR_W | Address for the instruction read |
| pm_rdata | input | DATA_W | Instruction word returned by program memory in the same cycle |
| instr_out | output | DATA_W | Instruction delivered to decode |
| instr_valid | output | 1 | `instr_out` is valid this cycle |
| stall | output | 1 | Pipeline must hold for one cycle (conflict miss) |
| hit_evt | output | 1 | Conflict lookup hit |
| miss_evt | output | 1 | Conflict lookup missed |
| evict_evt | output | 1 | The miss will replace a valid entry |

## Verification
The assertions assume that program memory answers the instruction read within the same cycle, and that `flush` arrives while no fetch is in progress. They also assume that the environment raises `conflict` only together with a fetch when it expects the cache to take part. The bench drives all inputs on the falling edge and returns a word computed from the address it reads. It pulses `flush` only on idle cycles. In fill cycles it keeps the fetch address steady, except for one directed case that drives unrelated values to show that they are ignored.

// File: rtl/icache_pkg.sv
package icache_pkg;

  localparam int unsigned NUM_WAYS = 2;

  typedef enum logic {
    ST_LOOKUP = 1'b0,
    ST_FILL   = 1'b1
  } ctl_state_e;

  // Empty way first (way 0 before way 1), otherwise the way the LRU pointer names.
  function automatic logic choose_victim(input logic way0_valid,
                                         input logic way1_valid,
                                         input logic lru_way);
    if (!way0_valid) return 1'b0;
    if (!way1_valid) return 1'b1;
    return lru_way;
  endfunction

  // After a way is used, the other way becomes the replacement candidate.
  function automatic logic lru_after_use(input logic used_way);
    return ~used_way;
  endfunction

endpackage

// File: rtl/icache_tag_array.sv
module icache_tag_array
  import icache_pkg::*;
#(
  parameter int unsigned INDEX_W = 4,
  parameter int unsigned TAG_W   = 12,
  localparam int unsigned SETS   = 1 << INDEX_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             flush,
  input  logic [INDEX_W-1:0]               rd_set,
  output logic [NUM_WAYS-1:0][TAG_W-1:0]   rd_tag,
  input  logic                             touch_en,
  input  logic [INDEX_W-1:0]               touch_set,
  input  logic                             touch_way,
  input  logic                             fill_en,
  input  logic [INDEX_W-1:0]               fill_set,
  input  logic                             fill_way,
  input  logic [TAG_W-1:0]                 fill_tag,
  output logic [NUM_WAYS*SETS-1:0]         valid_state,
  output logic [SETS-1:0]                  lru_state
);

  logic [SETS-1:0] lru_q;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic [SETS-1:0]  valid_q;
    logic [TAG_W-1:0] tag_q [SETS];
    logic             sel_fill;

    assign sel_fill = fill_en && (fill_way == 1'(w));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q <= '0;
      end else if (flush) begin
        valid_q <= '0;
      end else if (sel_fill) begin
        valid_q[fill_set] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (sel_fill && !flush) begin
        tag_q[fill_set] <= fill_tag;
      end
    end

    assign rd_tag[w]                     = tag_q[rd_set];
    assign valid_state[w*SETS +: SETS]   = valid_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lru_q <= '0;
    end else if (flush) begin
      lru_q <= '0;
    end else if (fill_en) begin
      lru_q[fill_set] <= lru_after_use(fill_way);
    end else if (touch_en) begin
      lru_q[touch_set] <= lru_after_use(touch_way);
    end
  end

  assign lru_state = lru_q;

endmodule

// File: rtl/icache_data_array.sv
module icache_data_array
  import icache_pkg::*;
#(
  parameter int unsigned INDEX_W = 4,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned SETS   = 1 << INDEX_W
) (
  input  logic                             clk,
  input  logic [INDEX_W-1:0]               rd_set,
  output logic [NUM_WAYS-1:0][DATA_W-1:0]  rd_data,
  input  logic                             wr_en,
  input  logic [INDEX_W-1:0]               wr_set,
  input  logic                             wr_way,
  input  logic [DATA_W-1:0]                wr_data
);

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic [DATA_W-1:0] word_q [SETS];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_way == 1'(w))) begin
        word_q[wr_set] <= wr_data;
      end
    end

    assign rd_data[w] = word_q[rd_set];
  end

endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              conflict,
  input  logic              freeze,
  input  logic              lookup_hit,
  input  logic              victim_way,
  input  logic              victim_valid,
  output logic              fill_cycle,
  output logic [ADDR_W-1:0] fill_addr,
  output logic              fill_way,
  output logic              fill_load,
  output logic              hit_evt,
  output logic              miss_evt,
  output logic              evict_evt,
  output logic              touch_en,
  output logic              stall
);

  ctl_state_e        state_q;
  logic [ADDR_W-1:0] fill_addr_q;
  logic              fill_way_q;
  logic              fill_load_q;
  logic              lookup_active;

  assign lookup_active = (state_q == ST_LOOKUP) && fetch_req && conflict;
  assign hit_evt       = lookup_active && lookup_hit;
  assign miss_evt      = lookup_active && !lookup_hit;
  assign evict_evt     = miss_evt && !freeze && victim_valid;
  assign touch_en      = hit_evt && !freeze;
  assign stall         = miss_evt;
  assign fill_cycle    = (state_q == ST_FILL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_LOOKUP;
      fill_addr_q <= '0;
      fill_way_q  <= 1'b0;
      fill_load_q <= 1'b0;
    end else begin
      case (state_q)
        ST_LOOKUP: begin
          if (miss_evt) begin
            state_q     <= ST_FILL;
            fill_addr_q <= fetch_addr;
            fill_way_q  <= victim_way;
            fill_load_q <= !freeze;
          end
        end
        default: begin
          state_q     <= ST_LOOKUP;
          fill_load_q <= 1'b0;
        end
      endcase
    end
  end

  assign fill_addr = fill_addr_q;
  assign fill_way  = fill_way_q;
  assign fill_load = fill_load_q;

endmodule

// File: rtl/pm_conflict_icache.sv
module pm_conflict_icache
  import icache_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned INDEX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              conflict,
  input  logic              freeze,
  output logic              pm_rd,
  output logic [ADDR_W-1:0] pm_addr,
  input  logic [DATA_W-1:0] pm_rdata,
  output logic [DATA_W-1:0] instr_out,
  output logic              instr_valid,
  output logic              stall,
  output logic              hit_evt,
  output logic              miss_evt,
  output logic              evict_evt
);

  localparam int unsigned SETS  = 1 << INDEX_W;
  localparam int unsigned TAG_W = ADDR_W - INDEX_W;

  // Lookup side
  logic [INDEX_W-1:0]               lookup_set;
  logic [TAG_W-1:0]                 lookup_tag;
  logic [NUM_WAYS-1:0][TAG_W-1:0]   way_tag;
  logic [NUM_WAYS-1:0][DATA_W-1:0]  way_data;
  logic [NUM_WAYS-1:0]              way_valid;
  logic [NUM_WAYS-1:0]              way_hit;
  logic                             lookup_hit;
  logic                             hit_way;
  logic                             lookup_lru;
  logic                             victim_way;
  logic                             victim_valid;

  // State views and events, named for the checker
  logic [NUM_WAYS*SETS-1:0]         valid_state;
  logic [SETS-1:0]                  lru_state;
  logic                             fill_cycle;
  logic                             touch_en;

  // Fill side
  logic [ADDR_W-1:0]                fill_addr;
  logic                             fill_way;
  logic                             fill_load;
  logic                             fill_wr;
  logic [INDEX_W-1:0]               fill_set;
  logic [TAG_W-1:0]                 fill_tag;

  assign lookup_set = fetch_addr[INDEX_W-1:0];
  assign lookup_tag = fetch_addr[ADDR_W-1:INDEX_W];
  assign fill_set   = fill_addr[INDEX_W-1:0];
  assign fill_tag   = fill_addr[ADDR_W-1:INDEX_W];
  assign fill_wr    = fill_cycle && fill_load && !flush;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    logic [SETS-1:0] valid_slice;
    assign valid_slice  = valid_state[w*SETS +: SETS];
    assign way_valid[w] = valid_slice[lookup_set];
    assign way_hit[w]   = way_valid[w] && (way_tag[w] == lookup_tag);
  end

  assign lookup_hit   = |way_hit;
  assign hit_way      = way_hit[1];
  assign lookup_lru   = lru_state[lookup_set];
  assign victim_way   = choose_victim(way_valid[0], way_valid[1], lookup_lru);
  assign victim_valid = way_valid[victim_way];

  icache_tag_array #(
    .INDEX_W (INDEX_W),
    .TAG_W   (TAG_W)
  ) u_tags (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .rd_set      (lookup_set),
    .rd_tag      (way_tag),
    .touch_en    (touch_en),
    .touch_set   (lookup_set),
    .touch_way   (hit_way),
    .fill_en     (fill_wr),
    .fill_set    (fill_set),
    .fill_way    (fill_way),
    .fill_tag    (fill_tag),
    .valid_state (valid_state),
    .lru_state   (lru_state)
  );

  icache_data_array #(
    .INDEX_W (INDEX_W),
    .DATA_W  (DATA_W)
  ) u_data (
    .clk     (clk),
    .rd_set  (lookup_set),
    .rd_data (way_data),
    .wr_en   (fill_wr),
    .wr_set  (fill_set),
    .wr_way  (fill_way),
    .wr_data (pm_rdata)
  );

  icache_ctrl #(
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_req    (fetch_req),
    .fetch_addr   (fetch_addr),
    .conflict     (conflict),
    .freeze       (freeze),
    .lookup_hit   (lookup_hit),
    .victim_way   (victim_way),
    .victim_valid (victim_valid),
    .fill_cycle   (fill_cycle),
    .fill_addr    (fill_addr),
    .fill_way     (fill_way),
    .fill_load    (fill_load),
    .hit_evt      (hit_evt),
    .miss_evt     (miss_evt),
    .evict_evt    (evict_evt),
    .touch_en     (touch_en),
    .stall        (stall)
  );

  // Bus and delivery steering
  always_comb begin
    pm_rd       = 1'b0;
    pm_addr     = '0;
    instr_out   = '0;
    instr_valid = 1'b0;
    if (fill_cycle) begin
      pm_rd       = 1'b1;
      pm_addr     = fill_addr;
      instr_out   = pm_rdata;
      instr_valid = 1'b1;
    end else if (fetch_req && !conflict) begin
      pm_rd       = 1'b1;
      pm_addr     = fetch_addr;
      instr_out   = pm_rdata;
      instr_valid = 1'b1;
    end else if (hit_evt) begin
      instr_out   = way_data[hit_way];
      instr_valid = 1'b1;
    end
  end

endmodule

// File: rtl/icache_checker.sv
module icache_checker #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned INDEX_W = 4,
  localparam int unsigned SETS   = 1 << INDEX_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              fetch_req,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              conflict,
  input logic              freeze,
  input logic              pm_rd,
  input logic [ADDR_W-1:0] pm_addr,
  input logic [DATA_W-1:0] pm_rdata,
  input logic [DATA_W-1:0] instr_out,
  input logic              instr_valid,
  input logic              stall,
  input logic              hit_evt,
  input logic              miss_evt,
  input logic              evict_evt,
  input logic              fill_cycle,
  input logic [2*SETS-1:0] valid_state,
  input logic [SETS-1:0]   lru_state
);

  // R1: plain fetch goes over the bus
  p_bypass_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !conflict && !fill_cycle) |->
      (pm_rd && pm_addr == fetch_addr && instr_out == pm_rdata && instr_valid && !stall));

  // R2: a hit leaves the bus to the data access and costs nothing
  p_hit_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |-> (!pm_rd && !stall && instr_valid));

  // R3: a miss stalls, then the next cycle reads the missed address
  p_miss_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |-> (stall && !instr_valid && !pm_rd));

  p_miss_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> (fill_cycle && pm_rd && instr_valid && pm_addr == $past(fetch_addr)));

  // R5: replacement only on an unfrozen miss
  p_evict_on_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evict_evt |-> (miss_evt && !freeze));

  // R7: frozen lookup cycles leave entries and pointers untouched
  p_freeze_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !flush && !fill_cycle) |=>
      (lru_state == $past(lru_state) && valid_state == $past(valid_state)));

  // R8: flush empties the cache
  p_flush_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_state == '0 && lru_state == '0));

  // R9: at most one lookup event per cycle, and no lookup while filling
  p_one_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_evt, miss_evt}) && !(fill_cycle && (hit_evt || miss_evt)));

  // R10: no request, no activity
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_req && !fill_cycle) |->
      (!instr_valid && !pm_rd && !stall && !hit_evt && !miss_evt));

endmodule

bind pm_conflict_icache icache_checker #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .INDEX_W (INDEX_W)
) u_icache_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush),
  .fetch_req   (fetch_req),
  .fetch_addr  (fetch_addr),
  .conflict    (conflict),
  .freeze      (freeze),
  .pm_rd       (pm_rd),
  .pm_addr     (pm_addr),
  .pm_rdata    (pm_rdata),
  .instr_out   (instr_out),
  .instr_valid (instr_valid),
  .stall       (stall),
  .hit_evt     (hit_evt),
  .miss_evt    (miss_evt),
  .evict_evt   (evict_evt),
  .fill_cycle  (fill_cycle),
  .valid_state (valid_state),
  .lru_state   (lru_state)
);

// File: tb/test_pm_conflict_icache.sv
module test_pm_conflict_icache;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush = 1'b0;
  logic          fetch_req = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic          conflict = 1'b0;
  logic          freeze = 1'b0;
  logic          pm_rd;
  logic [AW-1:0] pm_addr;
  logic [DW-1:0] pm_rdata;
  logic [DW-1:0] instr_out;
  logic          instr_valid;
  logic          stall;
  logic          hit_evt;
  logic          miss_evt;
  logic          evict_evt;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  // Reference model: per set, most and least recently used addresses
  logic [AW-1:0] m_mru [16];
  logic [AW-1:0] m_lru [16];
  int            m_cnt [16];
  logic          g_hit;
  logic          g_evict;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
    return {a ^ 16'hA5C3, ~a};
  endfunction

  assign pm_rdata = word_of(pm_addr);

  pm_conflict_icache #(.ADDR_W(AW), .DATA_W(DW), .INDEX_W(4)) i_pm_conflict_icache (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .conflict(conflict), .freeze(freeze),
    .pm_rd(pm_rd), .pm_addr(pm_addr), .pm_rdata(pm_rdata),
    .instr_out(instr_out), .instr_valid(instr_valid), .stall(stall),
    .hit_evt(hit_evt), .miss_evt(miss_evt), .evict_evt(evict_evt)
  );

  task automatic chk(input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic drive(input logic req, input logic [AW-1:0] a, input logic conf,
                       input logic frz, input logic fl);
    @(negedge clk);
    fetch_req  = req;
    fetch_addr = a;
    conflict   = conf;
    freeze     = frz;
    flush      = fl;
    #1;
  endtask

  task automatic model_clear();
    for (int s = 0; s < 16; s++) m_cnt[s] = 0;
  endtask

  task automatic do_flush();
    drive(1'b0, '0, 1'b0, 1'b0, 1'b1);
    model_clear();
  endtask

  // One conflicting fetch, including the fill cycle on a miss
  task automatic conflict_fetch(input logic [AW-1:0] a, input logic frz, input string rq);
    int  s;
    bit  exp_hit;
    bit  exp_evict;
    s         = int'(a[3:0]);
    exp_hit   = (m_cnt[s] > 0 && m_mru[s] == a) || (m_cnt[s] > 1 && m_lru[s] == a);
    exp_evict = !exp_hit && !frz && (m_cnt[s] == 2);
    drive(1'b1, a, 1'b1, frz, 1'b0);
    g_hit   = hit_evt;
    g_evict = evict_evt;
    chk(rq, "hit_evt", hit_evt, exp_hit);
    chk(rq, "miss_evt", miss_evt, !exp_hit);
    chk(rq, "evict_evt", evict_evt, exp_evict);
    chk(rq, "pm_rd in conflict", pm_rd, 1'b0);
    if (exp_hit) begin
      chk(rq, "stall on hit", stall, 1'b0);
      chk(rq, "cached instr", instr_out, word_of(a));
      chk(rq, "valid on hit", instr_valid, 1'b1);
      if (!frz && m_lru[s] == a && m_cnt[s] == 2) begin
        m_lru[s] = m_mru[s];
        m_mru[s] = a;
      end
    end else begin
      chk(rq, "stall on miss", stall, 1'b1);
      chk(rq, "valid on miss", instr_valid, 1'b0);
      drive(1'b1, a, 1'b0, frz, 1'b0);
      chk(rq, "fill pm_rd", pm_rd, 1'b1);
      chk(rq, "fill pm_addr", pm_addr, a);
      chk(rq, "fill instr", instr_out, word_of(a));
      chk(rq, "fill stall", stall, 1'b0);
      if (!frz) begin
        if (m_cnt[s] > 0) m_lru[s] = m_mru[s];
        m_mru[s] = a;
        if (m_cnt[s] < 2) m_cnt[s]++;
      end
    end
  endtask

  task automatic t_reset();
    chk("R8", "reset instr_valid", instr_valid, 1'b0);
    chk("R8", "reset stall", stall, 1'b0);
    chk("R8", "reset pm_rd", pm_rd, 1'b0);
    conflict_fetch(16'h0007, 1'b0, "R8");
    chk("R8", "empty after reset", g_hit, 1'b0);
  endtask

  task automatic t_bypass();
    logic [AW-1:0] addrs [4] = '{16'h0100, 16'h0231, 16'hBEEF, 16'h0007};
    do_flush();
    for (int i = 0; i < 4; i++) begin
      drive(1'b1, addrs[i], 1'b0, 1'b0, 1'b0);
      chk("R1", "bypass pm_rd", pm_rd, 1'b1);
      chk("R1", "bypass pm_addr", pm_addr, addrs[i]);
      chk("R1", "bypass instr", instr_out, word_of(addrs[i]));
      chk("R1", "bypass valid", instr_valid, 1'b1);
      chk("R1", "bypass stall", stall, 1'b0);
    end
    conflict_fetch(16'h0231, 1'b0, "R1");
    chk("R1", "bypass left cache unloaded", g_hit, 1'b0);
  endtask

  task automatic t_miss_hit();
    do_flush();
    drive(1'b1, 16'h0025, 1'b1, 1'b0, 1'b0);
    chk("R3", "miss_evt", miss_evt, 1'b1);
    chk("R3", "stall", stall, 1'b1);
    chk("R3", "valid", instr_valid, 1'b0);
    // Fill cycle with unrelated inputs: they are ignored
    drive(1'b0, 16'hFFF0, 1'b1, 1'b1, 1'b0);
    chk("R3", "fill pm_addr held", pm_addr, 16'h0025);
    chk("R3", "fill instr", instr_out, word_of(16'h0025));
    chk("R3", "fill valid", instr_valid, 1'b1);
    chk("R3", "no lookup in fill", hit_evt | miss_evt, 1'b0);
    m_mru[5] = 16'h0025;
    m_cnt[5] = 1;
    conflict_fetch(16'h0025, 1'b0, "R2");
    chk("R2", "loaded address hits", g_hit, 1'b1);
    drive(1'b1, 16'h0025, 1'b0, 1'b0, 1'b0);
    chk("R1", "cached address still bypasses", pm_rd, 1'b1);
  endtask

  task automatic t_mapping();
    do_flush();
    conflict_fetch(16'h0003, 1'b0, "R5");
    chk("R5", "first fill no evict", g_evict, 1'b0);
    conflict_fetch(16'h0013, 1'b0, "R5");
    chk("R5", "second way no evict", g_evict, 1'b0);
    conflict_fetch(16'h0004, 1'b0, "R4");
    conflict_fetch(16'h0003, 1'b0, "R6");
    chk("R6", "0x003 hits", g_hit, 1'b1);
    conflict_fetch(16'h0023, 1'b0, "R6");
    chk("R6", "third address evicts", g_evict, 1'b1);
    conflict_fetch(16'h0003, 1'b0, "R6");
    chk("R6", "recently used survives", g_hit, 1'b1);
    conflict_fetch(16'h0004, 1'b0, "R4");
    chk("R4", "other set untouched", g_hit, 1'b1);
    conflict_fetch(16'h0013, 1'b0, "R6");
    chk("R6", "LRU address replaced", g_hit, 1'b0);
  endtask

  task automatic t_thrash();
    logic [AW-1:0] loop_addr [3] = '{16'h0042, 16'h0052, 16'h0062};
    do_flush();
    for (int pass = 0; pass < 4; pass++) begin
      int ev = 0;
      for (int i = 0; i < 3; i++) begin
        conflict_fetch(loop_addr[i], 1'b0, "R9");
        if (g_evict) ev++;
      end
      chk("R9", "evictions per pass", 64'(ev), (pass == 0) ? 64'd1 : 64'd3);
    end
  endtask

  task automatic t_freeze();
    do_flush();
    conflict_fetch(16'h0105, 1'b0, "R7");
    conflict_fetch(16'h0205, 1'b0, "R7");
    conflict_fetch(16'h0105, 1'b1, "R7");
    chk("R7", "hit served in freeze", g_hit, 1'b1);
    conflict_fetch(16'h0305, 1'b1, "R7");
    chk("R7", "frozen miss no evict", g_evict, 1'b0);
    conflict_fetch(16'h0305, 1'b1, "R7");
    chk("R7", "frozen miss not loaded", g_hit, 1'b0);
    conflict_fetch(16'h0205, 1'b1, "R7");
    chk("R7", "entries kept", g_hit, 1'b1);
    conflict_fetch(16'h0305, 1'b0, "R7");
    chk("R7", "unfrozen miss evicts", g_evict, 1'b1);
    conflict_fetch(16'h0205, 1'b0, "R7");
    chk("R7", "frozen hit left LRU, other kept", g_hit, 1'b1);
    conflict_fetch(16'h0105, 1'b0, "R7");
    chk("R7", "LRU address was replaced", g_hit, 1'b0);
  endtask

  task automatic t_flush();
    conflict_fetch(16'h0555, 1'b0, "R8");
    conflict_fetch(16'h0555, 1'b0, "R8");
    chk("R8", "loaded before flush", g_hit, 1'b1);
    do_flush();
    conflict_fetch(16'h0555, 1'b0, "R8");
    chk("R8", "miss after flush", g_hit, 1'b0);
  endtask

  task automatic t_idle();
    drive(1'b0, 16'h0555, 1'b1, 1'b0, 1'b0);
    chk("R10", "idle valid", instr_valid, 1'b0);
    chk("R10", "idle pm_rd", pm_rd, 1'b0);
    chk("R10", "idle stall", stall, 1'b0);
    chk("R10", "idle events", {hit_evt, miss_evt}, 2'b00);
  endtask

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_bypass();
    t_miss_hit();
    t_mapping();
    t_thrash();
    t_freeze();
    t_flush();
    t_idle();
    drive(1'b0, '0, 1'b0, 1'b0, 1'b0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule